// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block keeps the coherence state of every line of one private cache that sits on a shared snooping bus. Each line is in one of four states: Modified, Exclusive, Shared or Invalid. The processor side presents one request at a time: a read, a write or an evict, together with a line index. The controller decides from the line's current state whether the request can finish locally or needs a bus transaction. A bus transaction is one of read, read-exclusive, invalidate or writeback. The controller raises a bus request and waits for the grant before it completes.

On the other side, the controller watches transactions that other caches put on the bus. For each one it drives a wired "shared" response and a "flush" response, which says that this cache supplies dirty data and memory takes it. It then lowers the state of its own copy. When its own read miss is granted, it samples the shared line and uses it to choose between Exclusive and Shared. This is what lets a later write to a clean line that no other cache holds finish with no invalidate on the bus.

The data array, memory and bus arbitration live outside the block. Per cycle, at most one agent owns the bus: either this cache's granted transaction or one snooped transaction.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: A read to an Invalid line issues bus command 1 (read). When the grant comes and the shared input is low, the line ends in Exclusive (state code 2).
- R2: A read to an Invalid line whose granted read sees the shared input high ends in Shared (state code 1).
- R3: A write to an Exclusive line ends in Modified (state code 3) with no bus request. A write to a Modified line also completes with no bus request and stays Modified.
- R4: A write to a Shared line issues bus command 3 (invalidate) and ends in Modified once granted.
- R5: A write to an Invalid line issues bus command 2 (read-exclusive) and ends in Modified once granted.
- R6: A Shared line is never promoted to Exclusive. Read hits and snooped reads leave it Shared.
- R7: A snooped read (command 1) that hits a valid local copy asserts sharedOut, and the copy ends in Shared. If the copy was Modified, flushOut is also asserted.
- R8: A snooped read-exclusive (2) or invalidate (3) moves a local copy to Invalid. It asserts flushOut when the copy was Modified. A snooped writeback (4) changes nothing.
- R9: Evicting a Modified line issues bus command 4 (writeback) and ends Invalid once granted. Evicting an Exclusive, Shared or Invalid line completes with no bus request and ends Invalid.
- R10: While a needed bus transaction is not granted, busReq stays high with a steady command and index, and reqDone stays low.
- R11: A read to a valid line completes in the same cycle with no bus request and no state change.
- R12: After reset every line is Invalid (code 0). Processor op codes are 0 read, 1 write, 2 evict.
- R13: While snoopValid is high, no processor request completes, and the snoop alone updates state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Processor request present; held until reqDone |
| reqOp | input | 2 | 0 read, 1 write, 2 evict |
| reqIdx | input | IDX_W | Line index of the request |
| reqDone | output | 1 | Request completes this cycle; state updates at the next edge |
| reqState | output | 2 | Current state of line reqIdx (0 I, 1 S, 2 E, 3 M) |
| busReq | output | 1 | Request for the bus |
| busCmd | output | 3 | Own bus command (0 none, 1 read, 2 read-exclusive, 3 invalidate, 4 writeback) |
| busIdx | output | IDX_W | Line index of the own bus command |
| busGnt | input | 1 | Bus granted this cycle; the transaction happens in this cycle |
| busSharedIn | input | 1 | Wired shared line, sampled during a granted read |
| snoopValid | input | 1 | Another agent's transaction is on the bus |
| snoopCmd | input | 3 | Snooped command, same encoding as busCmd |
| snoopIdx | input | IDX_W | Line index of the snooped command |
| sharedOut | output | 1 | This cache holds the snooped line (driven on a snooped read) |
| flushOut | output | 1 | This cache supplies dirty data of the snooped line and it is written back |

## Verification
The bench builds the block with four lines, so each line can be driven through every one of its four states. From each starting state it applies every processor operation, with both levels of the shared input and with grant delays of zero to two cycles, and from each state it applies every snooped command. A bench-side state model gives the expected command, completion cycle and final state for every combination. A collision case checks that a snoop stalls a pending local completion.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2,
    LS_MOD = 2'd3
  } lineState_t;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_EVICT = 2'd2,
    OP_RSVD  = 2'd3
  } procOp_t;

  typedef enum logic [2:0] {
    BC_IDLE  = 3'd0,
    BC_READ  = 3'd1,
    BC_READX = 3'd2,
    BC_INVAL = 3'd3,
    BC_WBACK = 3'd4
  } busCmd_t;

  // Strobes from control to the state store
  typedef struct packed {
    logic       wrEn;
    logic       wrSnoop;   // 1: write at snoop index, 0: at request index
    lineState_t wrState;
  } strobe_t;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] procIdx,
  input  logic [IDX_W-1:0] snoopIdx,
  input  strobe_t          strb,
  output lineState_t       procState,
  output lineState_t       snoopState
);
  lineState_t stateQ [NUM_LINES];

  generate
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      always_ff @(posedge clk) begin
        if (!rstN) begin
          stateQ[g] <= LS_INV;
        end else if (strb.wrEn &&
                     ((strb.wrSnoop ? snoopIdx : procIdx) == IDX_W'(g))) begin
          stateQ[g] <= strb.wrState;
        end
      end
    end
  endgenerate

  assign procState  = stateQ[procIdx];
  assign snoopState = stateQ[snoopIdx];
endmodule

// File: rtl/mesi_coh_ctrl.sv
module mesi_coh_ctrl
  import mesi_pkg::*;
(
  input  logic       reqValid,
  input  procOp_t    reqOp,
  input  lineState_t procState,
  input  logic       busGnt,
  input  logic       busSharedIn,
  input  logic       snoopValid,
  input  busCmd_t    snoopCmd,
  input  lineState_t snoopState,
  output logic       busReq,
  output busCmd_t    busCmd,
  output logic       reqDone,
  output logic       sharedOut,
  output logic       flushOut,
  output strobe_t    strb
);
  logic       needBus;
  busCmd_t    ownCmd;
  lineState_t reqNext;
  logic       snpHit;
  logic       snpWrite;
  lineState_t snpNext;

  // Processor side: decide from the current state, re-evaluated every
  // cycle so a snoop that lands while waiting for the grant is honoured.
  always_comb begin
    needBus = 1'b0;
    ownCmd  = BC_IDLE;
    reqNext = procState;
    unique case (reqOp)
      OP_READ: begin
        if (procState == LS_INV) begin
          needBus = 1'b1;
          ownCmd  = BC_READ;
          reqNext = busSharedIn ? LS_SHR : LS_EXC;
        end
      end
      OP_WRITE: begin
        reqNext = LS_MOD;
        if (procState == LS_SHR) begin
          needBus = 1'b1;
          ownCmd  = BC_INVAL;
        end else if (procState == LS_INV) begin
          needBus = 1'b1;
          ownCmd  = BC_READX;
        end
      end
      OP_EVICT: begin
        reqNext = LS_INV;
        if (procState == LS_MOD) begin
          needBus = 1'b1;
          ownCmd  = BC_WBACK;
        end
      end
      default: reqNext = procState;
    endcase
  end

  assign busReq  = reqValid && needBus;
  assign busCmd  = busReq ? ownCmd : BC_IDLE;
  assign reqDone = reqValid && !snoopValid && (!needBus || busGnt);

  // Snoop side
  always_comb begin
    snpHit    = snoopValid && (snoopState != LS_INV);
    sharedOut = 1'b0;
    flushOut  = 1'b0;
    snpWrite  = 1'b0;
    snpNext   = snoopState;
    case (snoopCmd)
      BC_READ: begin
        sharedOut = snpHit;
        flushOut  = snpHit && (snoopState == LS_MOD);
        snpWrite  = snpHit;
        snpNext   = LS_SHR;
      end
      BC_READX, BC_INVAL: begin
        flushOut = snpHit && (snoopState == LS_MOD);
        snpWrite = snpHit;
        snpNext  = LS_INV;
      end
      default: snpWrite = 1'b0;
    endcase
  end

  always_comb begin
    strb = '{wrEn: 1'b0, wrSnoop: 1'b0, wrState: LS_INV};
    if (snpWrite) begin
      strb = '{wrEn: 1'b1, wrSnoop: 1'b1, wrState: snpNext};
    end else if (reqDone) begin
      strb = '{wrEn: 1'b1, wrSnoop: 1'b0, wrState: reqNext};
    end
  end
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic [IDX_W-1:0] reqIdx,
  output logic             reqDone,
  output logic [1:0]       reqState,
  output logic             busReq,
  output logic [2:0]       busCmd,
  output logic [IDX_W-1:0] busIdx,
  input  logic             busGnt,
  input  logic             busSharedIn,
  input  logic             snoopValid,
  input  logic [2:0]       snoopCmd,
  input  logic [IDX_W-1:0] snoopIdx,
  output logic             sharedOut,
  output logic             flushOut
);
  strobe_t    strb;
  lineState_t procState;
  lineState_t snoopState;
  busCmd_t    cmdInt;

  mesi_line_store #(.NUM_LINES(NUM_LINES)) u_store (
    .clk        (clk),
    .rstN       (rstN),
    .procIdx    (reqIdx),
    .snoopIdx   (snoopIdx),
    .strb       (strb),
    .procState  (procState),
    .snoopState (snoopState)
  );

  mesi_coh_ctrl u_ctrl (
    .reqValid    (reqValid),
    .reqOp       (procOp_t'(reqOp)),
    .procState   (procState),
    .busGnt      (busGnt),
    .busSharedIn (busSharedIn),
    .snoopValid  (snoopValid),
    .snoopCmd    (busCmd_t'(snoopCmd)),
    .snoopState  (snoopState),
    .busReq      (busReq),
    .busCmd      (cmdInt),
    .reqDone     (reqDone),
    .sharedOut   (sharedOut),
    .flushOut    (flushOut),
    .strb        (strb)
  );

  assign busCmd   = cmdInt;
  assign busIdx   = reqIdx;
  assign reqState = procState;
endmodule

// File: rtl/mesi_snoop_ctrl_chk.sv
module mesi_snoop_ctrl_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [1:0]       reqOp,
  input logic [IDX_W-1:0] reqIdx,
  input logic             reqDone,
  input logic [1:0]       reqState,
  input logic             busReq,
  input logic [2:0]       busCmd,
  input logic [IDX_W-1:0] busIdx,
  input logic             busGnt,
  input logic             busSharedIn,
  input logic             snoopValid,
  input logic             flushOut
);
  // R1
  p_rd_miss_excl_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqDone && busCmd == 3'd1 && !busSharedIn) |=>
      (reqIdx != $past(reqIdx) || reqState == 2'd2));
  // R2
  p_rd_miss_shared_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqDone && busCmd == 3'd1 && busSharedIn) |=>
      (reqIdx != $past(reqIdx) || reqState == 2'd1));
  // R3
  p_excl_write_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 2'd1 && reqState == 2'd2) |-> !busReq);
  // R4
  p_shared_write_inval_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 2'd1 && reqState == 2'd1) |-> (busReq && busCmd == 3'd3));
  // R9
  p_evict_mod_wb_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 2'd2 && reqState == 2'd3) |-> (busReq && busCmd == 3'd4));
  // R10
  p_wait_grant_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busGnt) |-> !reqDone);
  p_busidx_r10: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> (busIdx == reqIdx));
  // R13
  p_snoop_stall_r13: assert property (@(posedge clk) disable iff (!rstN)
    snoopValid |-> !reqDone);
  // R8
  p_flush_on_snoop_r8: assert property (@(posedge clk) disable iff (!rstN)
    flushOut |-> snoopValid);
endmodule

bind mesi_snoop_ctrl mesi_snoop_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqOp       (reqOp),
  .reqIdx      (reqIdx),
  .reqDone     (reqDone),
  .reqState    (reqState),
  .busReq      (busReq),
  .busCmd      (busCmd),
  .busIdx      (busIdx),
  .busGnt      (busGnt),
  .busSharedIn (busSharedIn),
  .snoopValid  (snoopValid),
  .flushOut    (flushOut)
);

// File: tb/sim_mesi_snoop_ctrl.sv
`timescale 1ns/100ps
module sim_mesi_snoop_ctrl;
  localparam int NL = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [1:0]    reqOp = 2'd0;
  logic [IW-1:0] reqIdx = '0;
  logic          reqDone;
  logic [1:0]    reqState;
  logic          busReq;
  logic [2:0]    busCmd;
  logic [IW-1:0] busIdx;
  logic          busGnt = 1'b0;
  logic          busSharedIn = 1'b0;
  logic          snoopValid = 1'b0;
  logic [2:0]    snoopCmd = 3'd0;
  logic [IW-1:0] snoopIdx = '0;
  logic          sharedOut;
  logic          flushOut;

  int nChecks = 0;
  int nFails = 0;
  logic [1:0] model [NL];

  always #2.5 clk = ~clk;

  mesi_snoop_ctrl #(.NUM_LINES(NL)) u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic needBusF(input logic [1:0] op, input logic [1:0] st);
    return (op == 0 && st == 0) || (op == 1 && (st == 0 || st == 1)) ||
           (op == 2 && st == 3);
  endfunction

  function automatic logic [2:0] cmdF(input logic [1:0] op, input logic [1:0] st);
    if (op == 0 && st == 0) return 3'd1;
    if (op == 1 && st == 0) return 3'd2;
    if (op == 1 && st == 1) return 3'd3;
    if (op == 2 && st == 3) return 3'd4;
    return 3'd0;
  endfunction

  function automatic logic [1:0] nextF(input logic [1:0] op, input logic [1:0] st,
                                       input logic sh);
    if (op == 0) return (st == 0) ? (sh ? 2'd1 : 2'd2) : st;
    if (op == 1) return 2'd3;
    return 2'd0;
  endfunction

  function automatic string reqTag(input logic [1:0] op, input logic [1:0] st);
    if (op == 0) return (st == 0) ? "R1/R2" : "R11/R6";
    if (op == 1) return (st == 0) ? "R5" : (st == 1) ? "R4" : "R3";
    return "R9";
  endfunction

  task automatic doReq(input logic [1:0] op, input logic [IW-1:0] idx,
                       input logic sh, input int gntDelay);
    logic [1:0] st;
    logic nb;
    string tg;
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqIdx = idx; busSharedIn = sh; busGnt = 1'b0;
    #1;
    st = model[idx];
    nb = needBusF(op, st);
    tg = reqTag(op, st);
    chk(tg, reqState, st);
    chk(tg, busReq, nb);
    chk(tg, busCmd, cmdF(op, st));
    if (nb) begin
      for (int k = 0; k < gntDelay; k++) begin
        chk("R10", reqDone, 0);
        chk("R10", busReq, 1);
        chk("R10", busIdx, idx);
        @(negedge clk); #1;
        chk("R10", busCmd, cmdF(op, st));
      end
      busGnt = 1'b1;
      #1;
    end
    chk(tg, reqDone, 1);
    @(negedge clk);
    reqValid = 1'b0; busGnt = 1'b0; busSharedIn = 1'b0;
    model[idx] = nextF(op, st, sh);
    #1;
    chk(tg, reqState, model[idx]);
  endtask

  task automatic doSnoop(input logic [2:0] cmd, input logic [IW-1:0] idx);
    logic [1:0] st;
    logic expSh, expFl;
    @(negedge clk);
    snoopValid = 1'b1; snoopCmd = cmd; snoopIdx = idx;
    #1;
    st = model[idx];
    expSh = (cmd == 1) && (st != 0);
    expFl = (cmd >= 1 && cmd <= 3) && (st == 3);
    chk((cmd == 1) ? "R7" : "R8", sharedOut, expSh);
    chk((cmd == 1) ? "R7" : "R8", flushOut, expFl);
    @(negedge clk);
    snoopValid = 1'b0;
    if (cmd == 1 && st != 0) model[idx] = 2'd1;
    else if ((cmd == 2 || cmd == 3) && st != 0) model[idx] = 2'd0;
    reqIdx = idx;
    #1;
    chk((cmd == 1) ? "R7/R6" : "R8", reqState, model[idx]);
  endtask

  task automatic setState(input logic [IW-1:0] idx, input logic [1:0] s);
    doReq(2'd2, idx, 1'b0, 0);
    if (s == 1) doReq(2'd0, idx, 1'b1, 0);
    if (s == 2) doReq(2'd0, idx, 1'b0, 0);
    if (s == 3) doReq(2'd1, idx, 1'b0, 0);
  endtask

  initial begin
    for (int i = 0; i < NL; i++) model[i] = 2'd0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R12: reset state of every line
    for (int i = 0; i < NL; i++) begin
      @(negedge clk); reqIdx = IW'(i); #1;
      chk("R12", reqState, 0);
    end
    // Processor operations from every state
    for (int s = 0; s < 4; s++)
      for (int op = 0; op < 3; op++)
        for (int sh = 0; sh < 2; sh++)
          for (int d = 0; d < 3; d++) begin
            setState(IW'((s + op) % NL), 2'(s));
            doReq(2'(op), IW'((s + op) % NL), sh[0], d);
          end
    // Snooped commands from every state
    for (int s = 0; s < 4; s++)
      for (int c = 1; c < 5; c++) begin
        setState(IW'(c % NL), 2'(s));
        doSnoop(3'(c), IW'(c % NL));
      end
    // R6: Shared stays Shared after every other copy is gone
    setState(IW'(2), 2'd1);
    doReq(2'd0, IW'(2), 1'b0, 0);
    doReq(2'd1, IW'(2), 1'b0, 1);
    // R13: snoop stalls a local completion
    setState(IW'(3), 2'd2);
    @(negedge clk);
    reqValid = 1'b1; reqOp = 2'd1; reqIdx = IW'(3);
    snoopValid = 1'b1; snoopCmd = 3'd1; snoopIdx = IW'(3);
    #1;
    chk("R13", reqDone, 0);
    chk("R13", sharedOut, 1);
    @(negedge clk);
    snoopValid = 1'b0;
    #1;
    chk("R13", reqState, 1);
    chk("R13", busCmd, 3);
    busGnt = 1'b1; #1;
    chk("R13", reqDone, 1);
    @(negedge clk);
    reqValid = 1'b0; busGnt = 1'b0; #1;
    chk("R13", reqState, 3);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #500000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule